// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block sits on the receive byte stream of an Ethernet MAC and looks for a wake-on-LAN magic packet. When the enable input is high, the block asks the receive path to hold back normal frame delivery. It watches each incoming frame for a synchronization run of six 0xFF bytes, followed at once by sixteen back-to-back copies of the 48-bit station address.

A frame is considered only when its destination is the station address, the broadcast address or any multicast group. Source and destination fields are not searched for the synchronization run. The sequence may sit anywhere after them. A broken repetition sends the search back to looking for a new synchronization run in the same frame.

A detection is committed on the last byte of a frame that ends without an error mark. It sets a sticky flag and raises a one-cycle event that can drive an interrupt or a power-management wake request. Software clears the sticky flag with a one-cycle clear pulse.

Top module: `wol_detect`

## Requirements
- R1: `rx_hold_o` is high exactly when `enable_i` is high.
- R2: A frame is eligible only if its first six bytes equal the station address (most significant byte first), are all 0xFF, or its first byte has bit 0 set (multicast); any other unicast destination never produces a detection.
- R3: The synchronization run is six consecutive 0xFF bytes at byte index 12 or later (index 0 is the first destination byte); 0xFF bytes at indexes 0 to 11 do not count toward it.
- R4: A detection needs sixteen consecutive copies of the station address, compared most significant byte first, starting on the byte right after the synchronization run.
- R5: A byte that breaks the repetitions returns the detector to the synchronization search, and a complete sequence later in the same frame is still detected.
- R6: A run of more than six 0xFF bytes before the first address copy is accepted; the copies may follow any run of six or more.
- R7: A detection is reported only on a valid byte with `rx_eof_i` high, with `rx_err_i` low on that byte and `enable_i` high.
- R8: On a detection, `event_o` is high for exactly the one cycle after the end-of-frame byte, and `detected_o` becomes high in that same cycle and stays high.
- R9: A `clear_i` pulse clears `detected_o` in the next cycle, unless a detection happens in the same cycle, in which case the flag stays set.
- R10: After reset `detected_o` and `event_o` are low.
- R11: All match state restarts at start of frame, so a partial sequence from one frame never completes in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Detection mode enable |
| station_addr_i | input | 48 | Station address, byte 0 in bits 47:40 |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_err_i | input | 1 | Frame error, sampled with the last byte |
| rx_data_i | input | 8 | Receive byte |
| clear_i | input | 1 | Clear pulse for the sticky flag |
| detected_o | output | 1 | Sticky detection flag |
| event_o | output | 1 | One-cycle wake or interrupt request |
| rx_hold_o | output | 1 | Holds off normal frame delivery |

## Verification
The hardest situation to reach is a broken repetition run that recovers within the same frame. This includes the case where the breaking byte is itself 0xFF and begins a new synchronization run. Random frames seldom contain even one magic sequence by chance. The stimulus therefore writes sequences into random payloads at random offsets, sometimes corrupts one byte inside the repetitions, and sometimes places a second clean sequence after the damaged one. A reference function scans every frame for the pattern and decides the expected outcome. Directed frames cover over-long 0xFF runs, a 0xFF-filled source address, and a sequence split across two frames.

// File: rtl/wol_pkg.sv
package wol_pkg;
  parameter int unsigned MAC_BYTES = 6;
  typedef enum logic {ST_SYNC, ST_REP} scan_st_e;
endpackage

// File: rtl/wol_addr_filter.sv
module wol_addr_filter #(
  parameter int unsigned MAC_BYTES = wol_pkg::MAC_BYTES,
  parameter int unsigned HDR_BYTES = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   sof_i,
  input  logic [7:0]             data_i,
  input  logic [8*MAC_BYTES-1:0] station_i,
  output logic                   payload_o,
  output logic                   dest_ok_o
);
  localparam int unsigned IW = $clog2(HDR_BYTES + 1);
  localparam logic [IW-1:0] HDR_IDX = IW'(HDR_BYTES);
  localparam logic [IW-1:0] MAC_IDX = IW'(MAC_BYTES);

  logic [IW-1:0] idx_q, cur_idx;
  logic          in_dest, byte_match, is_ff;
  logic          uc_q, bc_q, mc_q;
  logic [8*MAC_BYTES-1:0] sh;
  int            shamt;

  always_comb begin
    cur_idx    = sof_i ? '0 : idx_q;
    in_dest    = cur_idx < MAC_IDX;
    shamt      = in_dest ? 8 * (MAC_BYTES - 1 - int'(cur_idx)) : 0;
    sh         = station_i >> shamt;
    byte_match = data_i == sh[7:0];
    is_ff      = data_i == 8'hFF;
    payload_o  = cur_idx == HDR_IDX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      uc_q  <= 1'b0;
      bc_q  <= 1'b0;
      mc_q  <= 1'b0;
    end else if (valid_i) begin
      idx_q <= (cur_idx == HDR_IDX) ? HDR_IDX : cur_idx + 1'b1;
      if (cur_idx == '0) begin
        uc_q <= byte_match;
        bc_q <= is_ff;
        mc_q <= data_i[0];
      end else if (in_dest) begin
        uc_q <= uc_q & byte_match;
        bc_q <= bc_q & is_ff;
      end
    end
  end

  assign dest_ok_o = uc_q | bc_q | mc_q;
endmodule

// File: rtl/wol_sync_scan.sv
module wol_sync_scan
  import wol_pkg::*;
#(
  parameter int unsigned MAC_BYTES = wol_pkg::MAC_BYTES,
  parameter int unsigned SYNC_LEN  = 6,
  parameter int unsigned REPS      = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   sof_i,
  input  logic                   payload_i,
  input  logic [7:0]             data_i,
  input  logic [8*MAC_BYTES-1:0] station_i,
  output logic                   hit_o
);
  localparam int unsigned RW = $clog2(SYNC_LEN + 1);
  localparam int unsigned SW = $clog2(MAC_BYTES);
  localparam int unsigned CW = $clog2(REPS);
  localparam logic [RW-1:0] RUN_MAX  = RW'(SYNC_LEN);
  localparam logic [SW-1:0] SEL_LAST = SW'(MAC_BYTES - 1);
  localparam logic [CW-1:0] REP_LAST = CW'(REPS - 1);

  scan_st_e      st_q;
  logic [RW-1:0] run_q, run_nxt;
  logic [SW-1:0] sel_q;
  logic [CW-1:0] rep_q;
  logic          found_q, match, done, sync_ok;
  logic [8*MAC_BYTES-1:0] sh;

  always_comb begin
    if (!payload_i || data_i != 8'hFF) run_nxt = '0;
    else if (run_q == RUN_MAX)         run_nxt = run_q;
    else                               run_nxt = run_q + 1'b1;
    sync_ok = run_nxt == RUN_MAX;
    sh      = station_i >> (8 * (MAC_BYTES - 1 - int'(sel_q)));
    match   = data_i == sh[7:0];
    done    = valid_i && !sof_i && payload_i && !found_q && st_q == ST_REP &&
              match && sel_q == SEL_LAST && rep_q == REP_LAST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SYNC;
      run_q   <= '0;
      sel_q   <= '0;
      rep_q   <= '0;
      found_q <= 1'b0;
    end else if (valid_i) begin
      if (sof_i) begin
        st_q    <= ST_SYNC;
        run_q   <= '0;
        sel_q   <= '0;
        rep_q   <= '0;
        found_q <= 1'b0;
      end else begin
        run_q <= run_nxt;
        if (payload_i && !found_q) begin
          if (st_q == ST_SYNC) begin
            if (sync_ok) begin
              st_q  <= ST_REP;
              sel_q <= '0;
              rep_q <= '0;
            end
          end else if (match) begin
            if (sel_q == SEL_LAST) begin
              sel_q <= '0;
              if (rep_q == REP_LAST) found_q <= 1'b1;
              else                   rep_q   <= rep_q + 1'b1;
            end else begin
              sel_q <= sel_q + 1'b1;
            end
          end else begin
            // a breaking 0xFF may still belong to a fresh sync run
            sel_q <= '0;
            rep_q <= '0;
            st_q  <= sync_ok ? ST_REP : ST_SYNC;
          end
        end
      end
    end
  end

  assign hit_o = found_q | done;
endmodule

// File: rtl/wol_wake_event.sv
module wol_wake_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic eof_i,
  input  logic err_i,
  input  logic enable_i,
  input  logic hit_i,
  input  logic dest_ok_i,
  input  logic clear_i,
  output logic detected_o,
  output logic event_o
);
  logic fire, det_q, evt_q;

  assign fire = valid_i & eof_i & ~err_i & enable_i & hit_i & dest_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= fire;
      det_q <= fire | (det_q & ~clear_i);
    end
  end

  assign detected_o = det_q;
  assign event_o    = evt_q;
endmodule

// File: rtl/wol_detect.sv
module wol_detect #(
  parameter int unsigned HDR_BYTES = 12,
  parameter int unsigned SYNC_LEN  = 6,
  parameter int unsigned REPS      = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic [47:0] station_addr_i,
  input  logic        rx_valid_i,
  input  logic        rx_sof_i,
  input  logic        rx_eof_i,
  input  logic        rx_err_i,
  input  logic [7:0]  rx_data_i,
  input  logic        clear_i,
  output logic        detected_o,
  output logic        event_o,
  output logic        rx_hold_o
);
  localparam int unsigned MB = wol_pkg::MAC_BYTES;

  logic payload, dest_ok, hit;

  wol_addr_filter #(.MAC_BYTES(MB), .HDR_BYTES(HDR_BYTES)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .sof_i     (rx_sof_i),
    .data_i    (rx_data_i),
    .station_i (station_addr_i),
    .payload_o (payload),
    .dest_ok_o (dest_ok)
  );

  wol_sync_scan #(.MAC_BYTES(MB), .SYNC_LEN(SYNC_LEN), .REPS(REPS)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .sof_i     (rx_sof_i),
    .payload_i (payload),
    .data_i    (rx_data_i),
    .station_i (station_addr_i),
    .hit_o     (hit)
  );

  wol_wake_event u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .eof_i      (rx_eof_i),
    .err_i      (rx_err_i),
    .enable_i   (enable_i),
    .hit_i      (hit),
    .dest_ok_i  (dest_ok),
    .clear_i    (clear_i),
    .detected_o (detected_o),
    .event_o    (event_o)
  );

  assign rx_hold_o = enable_i;
endmodule

// File: rtl/wol_detect_chk.sv
module wol_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic rx_valid_i,
  input logic rx_eof_i,
  input logic rx_err_i,
  input logic clear_i,
  input logic detected_o,
  input logic event_o
);
  // R8
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> detected_o);

  // R8
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);

  // R8
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detected_o) |-> event_o);

  // R7
  evt_at_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(rx_valid_i && rx_eof_i && enable_i && !rx_err_i));

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(rx_valid_i && rx_eof_i) && !clear_i) |=> $stable(detected_o));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !(rx_valid_i && rx_eof_i)) |=> !detected_o);
endmodule

bind wol_detect wol_detect_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .rx_valid_i (rx_valid_i),
  .rx_eof_i   (rx_eof_i),
  .rx_err_i   (rx_err_i),
  .clear_i    (clear_i),
  .detected_o (detected_o),
  .event_o    (event_o)
);

// File: tb/sim_wol_detect.sv
module sim_wol_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [47:0] station = '0;
  logic        valid = 1'b0, sof = 1'b0, eof = 1'b0, err = 1'b0, clear = 1'b0;
  logic [7:0]  data = '0;
  logic        detected, evt, hold;

  int checks = 0;
  int errors = 0;
  logic [7:0] fr [256];

  always #4 clk = ~clk;

  wol_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .station_addr_i(station),
    .rx_valid_i(valid), .rx_sof_i(sof), .rx_eof_i(eof), .rx_err_i(err),
    .rx_data_i(data), .clear_i(clear),
    .detected_o(detected), .event_o(evt), .rx_hold_o(hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sb(input int k);
    return station[8*(5-k) +: 8];
  endfunction

  function automatic bit ref_hit(input int len);
    bit uc = 1, bc = 1, mc, found = 0;
    mc = fr[0][0];
    for (int k = 0; k < 6; k++) begin
      if (fr[k] != sb(k)) uc = 0;
      if (fr[k] != 8'hFF) bc = 0;
    end
    for (int p = 12; p + 102 <= len; p++) begin
      bit ok = 1;
      for (int k = 0; k < 6; k++) if (fr[p+k] != 8'hFF) ok = 0;
      for (int k = 0; k < 96; k++) if (fr[p+6+k] != sb(k % 6)) ok = 0;
      if (ok) found = 1;
    end
    return found && (uc || bc || mc);
  endfunction

  task automatic put_dest(input int kind);
    for (int k = 0; k < 6; k++) begin
      case (kind)
        0: fr[k] = sb(k);
        1: fr[k] = 8'hFF;
        2: fr[k] = 8'($urandom_range(0, 255));
        default: fr[k] = sb(k);
      endcase
    end
    if (kind == 2) fr[0][0] = 1'b1;
    if (kind == 3) begin
      fr[0][0] = 1'b0;
      fr[5] = fr[5] ^ 8'h01;
    end
  endtask

  task automatic put_magic(input int p, input int sync_len);
    for (int k = 0; k < sync_len; k++) fr[p+k] = 8'hFF;
    for (int k = 0; k < 96; k++) fr[p+sync_len+k] = sb(k % 6);
  endtask

  task automatic fill_rand(input int len);
    for (int k = 0; k < len; k++) fr[k] = 8'($urandom_range(0, 255));
  endtask

  task automatic send(input int len, input bit er, input bit clr_eof, input bit gaps);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gaps && $urandom_range(0, 7) == 0) begin
        valid = 1'b0; sof = 1'b0; eof = 1'b0; err = 1'b0;
        @(negedge clk);
      end
      valid = 1'b1;
      data  = fr[i];
      sof   = (i == 0);
      eof   = (i == len - 1);
      err   = er && (i == len - 1);
      clear = clr_eof && (i == len - 1);
    end
    @(negedge clk);
    valid = 1'b0; sof = 1'b0; eof = 1'b0; err = 1'b0; clear = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  // send, then check the cycle after the last byte and the one after it
  task automatic run_frame(input string req, input int len, input bit er, input bit exp);
    do_clear();
    send(len, er, 1'b0, 1'b1);
    check(req, {31'd0, evt}, {31'd0, exp});
    check(req, {31'd0, detected}, {31'd0, exp});
    @(negedge clk);
    check("R8 pulse", {31'd0, evt}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    station = 48'h02_1A_3C_44_5E_67;
    repeat (3) @(negedge clk);
    check("R10 det", {31'd0, detected}, 32'd0);
    check("R10 evt", {31'd0, evt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 off", {31'd0, hold}, 32'd0);
    enable = 1'b1;
    @(negedge clk);
    check("R1 on", {31'd0, hold}, 32'd1);

    // R4: unicast, sequence right after the address fields
    fill_rand(130); put_dest(0); put_magic(12, 6);
    run_frame("R4 basic", 130, 1'b0, 1'b1);

    // R9: clear coinciding with a new detection keeps the flag
    send(130, 1'b0, 1'b1, 1'b0);
    check("R9 coincident", {31'd0, detected}, 32'd1);
    do_clear();
    check("R9 cleared", {31'd0, detected}, 32'd0);

    // R3: 0xFF source address must not serve as sync
    fill_rand(120); put_dest(0);
    for (int k = 6; k < 12; k++) fr[k] = 8'hFF;
    for (int k = 0; k < 96; k++) fr[12+k] = sb(k % 6);
    run_frame("R3 hdr ff", 120, 1'b0, 1'b0);

    // R6: long 0xFF run
    fill_rand(140); put_dest(0); put_magic(20, 9);
    run_frame("R6 long run", 140, 1'b0, 1'b1);

    // R5: broken repetition, then clean sequence in same frame
    fill_rand(240); put_dest(0); put_magic(14, 6);
    fr[14+6+35] = 8'h00;
    run_frame("R5 broken only", 240, 1'b0, 1'b0);
    fr[14+6+35] = 8'hFF;
    put_magic(14+6+36, 6);
    run_frame("R5 recover", 240, 1'b0, 1'b1);

    // R7: error flag and disabled mode
    fill_rand(130); put_dest(1); put_magic(16, 6);
    run_frame("R7 err", 130, 1'b1, 1'b0);
    enable = 1'b0;
    run_frame("R7 disabled", 130, 1'b0, 1'b0);
    check("R1 off again", {31'd0, hold}, 32'd0);
    enable = 1'b1;

    // R11: sequence split across two frames
    fill_rand(60); put_dest(0);
    for (int k = 0; k < 6; k++) fr[40+k] = 8'hFF;
    for (int k = 0; k < 14; k++) fr[46+k] = sb(k % 6);
    run_frame("R11 first", 60, 1'b0, 1'b0);
    fill_rand(120); put_dest(0);
    for (int k = 0; k < 82; k++) fr[12+k] = sb((k + 14) % 6);
    run_frame("R11 second", 120, 1'b0, 1'b0);

    // R2: destination kinds
    fill_rand(130); put_dest(1); put_magic(12, 6);
    run_frame("R2 bcast", 130, 1'b0, 1'b1);
    put_dest(2);
    run_frame("R2 mcast", 130, 1'b0, 1'b1);
    put_dest(3);
    run_frame("R2 other", 130, 1'b0, 1'b0);

    // random frames against the reference
    for (int n = 0; n < 220; n++) begin
      int len, kind, p;
      bit er, en, exp;
      string req;
      if (n % 40 == 0)
        for (int k = 0; k < 6; k++) station[8*k +: 8] = 8'($urandom_range(0, 254));
      station[40] = 1'b0;
      len  = $urandom_range(64, 240);
      kind = $urandom_range(0, 3);
      er   = ($urandom_range(0, 7) == 0);
      en   = ($urandom_range(0, 9) != 0);
      fill_rand(len); put_dest(kind);
      if ($urandom_range(0, 3) != 0 && len >= 114) begin
        p = $urandom_range(12, len - 102);
        put_magic(p, 6);
        if ($urandom_range(0, 2) == 0) begin
          fr[p + 6 + $urandom_range(0, 95)] = 8'($urandom_range(0, 255));
          if (p + 204 <= len && $urandom_range(0, 1) == 1) put_magic(p + 102, 6);
        end
      end
      exp = en && !er && ref_hit(len);
      req = (kind == 3) ? "R2 rand" : (er ? "R7 rand" : "R5 rand");
      enable = en;
      run_frame(req, len, er, exp);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule